// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects up to 96 level-sensitive interrupt sources, arranged as three banks of 32, and presents them to a processor as two request lines: a normal request and a fast request. Each source can be blocked by a mask bit, or raised by software through a per-source software bit. A per-source level word gives the source a 6-bit priority and steers it to one of the two request lines.

For each request line, an arbiter picks the most urgent pending source and loads its number into a winner register. The winner register then stays frozen until software writes a release bit, so an interrupt service routine always reads a stable source number. All state is held in registers on a simple 32-bit word bus with one-cycle read latency. A software-triggered soft reset returns all configuration to its reset values.

Top module: `prio_intc`

## Requirements
- R1: After reset, every mask register (bank offset +0x04) reads 0xFFFFFFFF. The revision register at 0x00 reads {major[7:4], minor[3:0]}, which is 0x21 by default. The status register at 0x14 reads 1 in bit 0. Both request outputs are low.
- R2: Source n belongs to bank n[6:5] at bit n[4:0]. Bank b occupies 0x80+0x20*b. Its +0x00 word returns the raw input levels of that bank.
- R3: Writing the mask word (+0x04) replaces the mask. Writing 1s to +0x0C sets mask bits, and writing 1s to +0x08 clears them. Zero bits in either alias leave their mask bits unchanged. A mask bit of 1 blocks its source.
- R4: Writing 1s to +0x10 sets software bits, and writing 1s to +0x14 clears them. A set software bit makes its source behave as if its input were high.
- R5: A source is active when (input OR software bit) AND NOT mask. Its level word bit 0 decides the line: 0 means normal, 1 means fast. +0x18 shows the active normal sources and +0x1C shows the active fast sources.
- R6: The winner is the active source with the smallest priority value, where 0 is the most urgent. Among equal priorities, the lowest source number wins. The normal winner reads at 0x40 and the fast winner at 0x44, in bits [6:0].
- R7: Once a winner is captured, its register holds even if sources change. Writing bit 0 to 0x48 releases the normal winner, and writing bit 1 releases the fast winner. Releasing one line does not disturb the other.
- R8: A winner register that has no active source for its line reads 0x80, with bit 7 acting as a spurious flag.
- R9: irq_o is high exactly one cycle after any normal source is active. fiq_o does the same for fast sources.
- R10: Writing bit 1 of 0x10 starts a soft reset. One cycle later, masks are all 1s, software bits and level words are 0, and both winners read 0x80. Once the reset is done, 0x14 bit 0 reads 1.
- R11: The level word of source n sits at 0x100+4*n. Bits [7:2] hold the priority and bit 0 holds the line select. Bit 1 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data is valid the next cycle |
| bus_addr | input | 10 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_i | input | 96 | Level-sensitive source inputs |
| irq_o | output | 1 | Normal request line |
| fiq_o | output | 1 | Fast request line |

## Verification
Each fault has a distinct signature at the ports:

- A corrupted mask or software bit shows up at the pending words and the request lines on the very next cycle.
- A wrong arbiter choice shows up at the winner register one cycle after arbitration.
- A winner latch that fails to hold shows up as a changed source number when a more urgent source arrives before release.

The tests deliberately bring in a more urgent source while a winner is held, create a priority tie, and release with nothing pending, so that each of these faults appears within two cycles.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int BANK_W      = 32;
  localparam int OFF_REV     = 'h000;
  localparam int OFF_SYSCFG  = 'h010;
  localparam int OFF_STATUS  = 'h014;
  localparam int OFF_WIN_N   = 'h040;
  localparam int OFF_WIN_F   = 'h044;
  localparam int OFF_CTRL    = 'h048;
  localparam int OFF_BANK    = 'h080;
  localparam int BANK_STRIDE = 'h020;
  localparam int OFF_LEVEL   = 'h100;
  localparam int WIN_W       = 8;
  localparam logic [WIN_W-1:0] WIN_NONE = 8'h80;

  // word index inside a bank window
  typedef enum logic [2:0] {
    SUB_RAW   = 3'd0,
    SUB_MASK  = 3'd1,
    SUB_MCLR  = 3'd2,
    SUB_MSET  = 3'd3,
    SUB_SWSET = 3'd4,
    SUB_SWCLR = 3'd5,
    SUB_PNDN  = 3'd6,
    SUB_PNDF  = 3'd7
  } bank_sub_e;
endpackage

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int W = BANK_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [2:0]   sub,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] src,
  input  logic [W-1:0] fast_sel,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] pend_n,
  output logic [W-1:0] pend_f
);
  logic [W-1:0] sw_q;
  logic [W-1:0] active;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      sw_q   <= '0;
    end else if (wr_en) begin
      case (bank_sub_e'(sub))
        SUB_MASK:  mask_q <= wdata;
        SUB_MCLR:  mask_q <= mask_q & ~wdata;
        SUB_MSET:  mask_q <= mask_q | wdata;
        SUB_SWSET: sw_q   <= sw_q | wdata;
        SUB_SWCLR: sw_q   <= sw_q & ~wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    active = (src | sw_q) & ~mask_q;
    pend_n = active & ~fast_sel;
    pend_f = active & fast_sel;
  end

  assert_mask_set_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sub == 3'd3) |=> ((mask_q & $past(wdata)) == $past(wdata)));

  assert_sw_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sub == 3'd5) |=> ((sw_q & $past(wdata)) == '0));

  assert_line_split_R5: assert property (@(posedge clk) disable iff (rst)
    (pend_n & pend_f) == '0);
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int N      = 96,
  parameter int PRIO_W = 6,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        pend,
  input  logic [N*PRIO_W-1:0] prio_flat,
  output logic                valid,
  output logic [IDX_W-1:0]    idx
);
  logic [PRIO_W-1:0] best;

  // scan from the top down; "<=" lets a lower number take a tie
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    best  = '1;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i] && (!valid || prio_flat[i*PRIO_W +: PRIO_W] <= best)) begin
        valid = 1'b1;
        best  = prio_flat[i*PRIO_W +: PRIO_W];
        idx   = IDX_W'(i);
      end
    end
  end

  assert_pick_pending_R6: assert property (@(posedge clk) disable iff (rst)
    valid |-> pend[idx]);

  assert_none_pending_R8: assert property (@(posedge clk) disable iff (rst)
    !valid |-> (pend == '0));
endmodule

// File: rtl/intc_winner.sv
module intc_winner
  import intc_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             release_i,
  input  logic             arb_valid,
  input  logic [IDX_W-1:0] arb_idx,
  output logic [WIN_W-1:0] win_q
);
  logic free_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      free_q <= 1'b1;
      win_q  <= WIN_NONE;
    end else if (free_q || release_i) begin
      free_q <= !arb_valid;
      win_q  <= arb_valid ? WIN_W'(arb_idx) : WIN_NONE;
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!free_q && !release_i) |=> $stable(win_q));

  assert_spurious_free_R8: assert property (@(posedge clk) disable iff (rst)
    win_q[7] |-> free_q);
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int PRIO_W    = 6,
  parameter int ADDR_W    = 10,
  parameter int REV_MAJOR = 2,
  parameter int REV_MINOR = 1,
  localparam int SRC_N    = NUM_BANKS * BANK_W,
  localparam int IDX_W    = $clog2(SRC_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [SRC_N-1:0]  src_i,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam logic [ADDR_W-1:0] BANK_LO = ADDR_W'(OFF_BANK);
  localparam logic [ADDR_W-1:0] BANK_HI = ADDR_W'(OFF_BANK + BANK_STRIDE * NUM_BANKS);
  localparam logic [ADDR_W-1:0] LVL_LO  = ADDR_W'(OFF_LEVEL);
  localparam logic [ADDR_W-1:0] LVL_HI  = ADDR_W'(OFF_LEVEL + 4 * SRC_N);

  logic srst_q, rst_all;
  assign rst_all = rst | srst_q;

  // address decode
  logic              word_ok, bank_hit, lvl_hit;
  logic [ADDR_W-1:0] bank_num, lvl_num;
  assign word_ok  = (bus_addr[1:0] == 2'b00);
  assign bank_hit = word_ok && bus_addr >= BANK_LO && bus_addr < BANK_HI;
  assign lvl_hit  = word_ok && bus_addr >= LVL_LO && bus_addr < LVL_HI;
  assign bank_num = (bus_addr - BANK_LO) >> 5;
  assign lvl_num  = (bus_addr - LVL_LO) >> 2;

  logic ctrl_wr;
  assign ctrl_wr = bus_wr && word_ok && bus_addr == ADDR_W'(OFF_CTRL);

  always_ff @(posedge clk) begin
    if (rst) srst_q <= 1'b0;
    else     srst_q <= bus_wr && word_ok && bus_addr == ADDR_W'(OFF_SYSCFG) && bus_wdata[1];
  end

  // per-source level words
  logic [PRIO_W-1:0]       lvl_prio [SRC_N];
  logic [SRC_N-1:0]        lvl_fast;
  logic [SRC_N*PRIO_W-1:0] prio_flat;

  always_ff @(posedge clk) begin
    if (rst_all) begin
      for (int i = 0; i < SRC_N; i++) begin
        lvl_prio[i] <= '0;
        lvl_fast[i] <= 1'b0;
      end
    end else if (bus_wr && lvl_hit) begin
      for (int i = 0; i < SRC_N; i++) begin
        if (lvl_num == ADDR_W'(i)) begin
          lvl_prio[i] <= bus_wdata[2 +: PRIO_W];
          lvl_fast[i] <= bus_wdata[0];
        end
      end
    end
  end

  genvar s;
  generate
    for (s = 0; s < SRC_N; s++) begin : g_flat
      assign prio_flat[s*PRIO_W +: PRIO_W] = lvl_prio[s];
    end
  endgenerate

  // banks
  logic [BANK_W-1:0] mask_b [NUM_BANKS];
  logic [SRC_N-1:0]  pend_n, pend_f;

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      intc_bank #(.W(BANK_W)) u_bank (
        .clk      (clk),
        .rst      (rst_all),
        .wr_en    (bus_wr && bank_hit && bank_num == ADDR_W'(b)),
        .sub      (bus_addr[4:2]),
        .wdata    (bus_wdata),
        .src      (src_i[b*BANK_W +: BANK_W]),
        .fast_sel (lvl_fast[b*BANK_W +: BANK_W]),
        .mask_q   (mask_b[b]),
        .pend_n   (pend_n[b*BANK_W +: BANK_W]),
        .pend_f   (pend_f[b*BANK_W +: BANK_W])
      );
    end
  endgenerate

  // one arbiter and winner latch per request line (0 = normal, 1 = fast)
  logic [WIN_W-1:0] win [2];

  genvar l;
  generate
    for (l = 0; l < 2; l++) begin : g_line
      logic             a_valid;
      logic [IDX_W-1:0] a_idx;

      intc_arbiter #(.N(SRC_N), .PRIO_W(PRIO_W)) u_arb (
        .clk       (clk),
        .rst       (rst_all),
        .pend      ((l == 0) ? pend_n : pend_f),
        .prio_flat (prio_flat),
        .valid     (a_valid),
        .idx       (a_idx)
      );

      intc_winner #(.IDX_W(IDX_W)) u_win (
        .clk       (clk),
        .rst       (rst_all),
        .release_i (ctrl_wr && bus_wdata[l]),
        .arb_valid (a_valid),
        .arb_idx   (a_idx),
        .win_q     (win[l])
      );
    end
  endgenerate

  // registered request lines
  always_ff @(posedge clk) begin
    if (rst_all) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= |pend_n;
      fiq_o <= |pend_f;
    end
  end

  // read path
  logic [31:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (word_ok) begin
      case (bus_addr)
        ADDR_W'(OFF_REV):    rd_mux = 32'({4'(REV_MAJOR), 4'(REV_MINOR)});
        ADDR_W'(OFF_STATUS): rd_mux = {31'd0, ~srst_q};
        ADDR_W'(OFF_WIN_N):  rd_mux = 32'(win[0]);
        ADDR_W'(OFF_WIN_F):  rd_mux = 32'(win[1]);
        default: ;
      endcase
    end
    if (bank_hit) begin
      for (int k = 0; k < NUM_BANKS; k++) begin
        if (bank_num == ADDR_W'(k)) begin
          case (bank_sub_e'(bus_addr[4:2]))
            SUB_RAW:  rd_mux = src_i[k*BANK_W +: BANK_W];
            SUB_MASK: rd_mux = mask_b[k];
            SUB_PNDN: rd_mux = pend_n[k*BANK_W +: BANK_W];
            SUB_PNDF: rd_mux = pend_f[k*BANK_W +: BANK_W];
            default:  rd_mux = '0;
          endcase
        end
      end
    end
    if (lvl_hit) begin
      for (int k = 0; k < SRC_N; k++) begin
        if (lvl_num == ADDR_W'(k)) rd_mux = 32'({lvl_prio[k], 1'b0, lvl_fast[k]});
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assert_soft_clear_R10: assert property (@(posedge clk) disable iff (rst)
    srst_q |=> (lvl_fast == '0));
endmodule

// File: tb/prio_intc_tb.sv
module prio_intc_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr, bus_rd;
  logic [9:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [95:0] src_i;
  logic        irq_o, fiq_o;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  prio_intc u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_i(src_i), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  typedef struct packed {
    logic        wr;
    logic [9:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 47;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 10'h084, 32'hFFFFFFFF, 4'd1},  // R1 bank0 masked
    '{1'b0, 10'h0A4, 32'hFFFFFFFF, 4'd1},  // R1 bank1 masked
    '{1'b1, 10'h114, 32'h00000028, 4'd11}, // src5 prio 10, normal
    '{1'b0, 10'h114, 32'h00000028, 4'd11}, // R11
    '{1'b1, 10'h194, 32'h0000000D, 4'd11}, // src37 prio 3, fast
    '{1'b0, 10'h194, 32'h0000000D, 4'd11}, // R11
    '{1'b1, 10'h108, 32'h0000000A, 4'd11}, // src2 prio 2, bit1 written
    '{1'b0, 10'h108, 32'h00000008, 4'd11}, // R11 bit1 reads 0
    '{1'b1, 10'h088, 32'h00000020, 4'd3},  // unmask src5
    '{1'b0, 10'h084, 32'hFFFFFFDF, 4'd3},  // R3
    '{1'b1, 10'h090, 32'h00000020, 4'd4},  // sw raise src5
    '{1'b0, 10'h098, 32'h00000020, 4'd5},  // R5 normal pending
    '{1'b0, 10'h040, 32'h00000005, 4'd6},  // R6
    '{1'b1, 10'h0A8, 32'h00000020, 4'd3},  // unmask src37
    '{1'b1, 10'h0B0, 32'h00000020, 4'd4},  // sw raise src37
    '{1'b0, 10'h0BC, 32'h00000020, 4'd5},  // R5 fast pending
    '{1'b0, 10'h0B8, 32'h00000000, 4'd5},  // R5 not on normal
    '{1'b0, 10'h044, 32'h00000025, 4'd6},  // R6 fast winner 37
    '{1'b1, 10'h088, 32'h00000004, 4'd3},  // unmask src2
    '{1'b1, 10'h090, 32'h00000004, 4'd4},  // raise src2
    '{1'b0, 10'h098, 32'h00000024, 4'd5},  // R5
    '{1'b0, 10'h040, 32'h00000005, 4'd7},  // R7 held despite src2
    '{1'b1, 10'h048, 32'h00000001, 4'd7},  // release normal
    '{1'b0, 10'h040, 32'h00000002, 4'd7},  // R7 new winner
    '{1'b0, 10'h044, 32'h00000025, 4'd7},  // R7 fast untouched
    '{1'b1, 10'h118, 32'h00000008, 4'd6},  // src6 prio 2
    '{1'b1, 10'h124, 32'h00000008, 4'd6},  // src9 prio 2
    '{1'b1, 10'h088, 32'h00000240, 4'd3},
    '{1'b1, 10'h090, 32'h00000240, 4'd4},
    '{1'b1, 10'h094, 32'h00000004, 4'd4},  // drop src2
    '{1'b0, 10'h098, 32'h00000260, 4'd4},  // R4 sw clear
    '{1'b1, 10'h048, 32'h00000001, 4'd7},
    '{1'b0, 10'h040, 32'h00000006, 4'd6},  // R6 tie -> lower number
    '{1'b1, 10'h08C, 32'h00000040, 4'd3},  // mask src6
    '{1'b0, 10'h084, 32'hFFFFFDDB, 4'd3},  // R3 others unchanged
    '{1'b1, 10'h048, 32'h00000001, 4'd7},
    '{1'b0, 10'h040, 32'h00000009, 4'd6},  // R6
    '{1'b1, 10'h084, 32'hFFFFFFFF, 4'd3},  // full mask write
    '{1'b0, 10'h098, 32'h00000000, 4'd3},  // R3
    '{1'b1, 10'h048, 32'h00000001, 4'd7},
    '{1'b0, 10'h040, 32'h00000080, 4'd8},  // R8 spurious
    '{1'b1, 10'h0B4, 32'h00000020, 4'd4},  // drop src37
    '{1'b0, 10'h0BC, 32'h00000000, 4'd4},  // R4
    '{1'b0, 10'h044, 32'h00000025, 4'd7},  // R7 still held
    '{1'b1, 10'h048, 32'h00000002, 4'd7},  // release fast
    '{1'b0, 10'h044, 32'h00000080, 4'd8},  // R8
    '{1'b0, 10'h040, 32'h00000080, 4'd7}   // R7 normal unaffected
  };

  task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bwrite(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic bread(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    @(negedge clk);
  endtask

  task automatic rcheck(input int req, input logic [9:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bread(a, v);
    check(req, v, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0; src_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check(1, {31'd0, irq_o}, 32'd0);
    check(1, {31'd0, fiq_o}, 32'd0);
    rcheck(1, 10'h000, 32'h21);
    rcheck(1, 10'h014, 32'h1);
    rcheck(8, 10'h040, 32'h80);  // R8
    rcheck(8, 10'h044, 32'h80);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) bwrite(VEC[i].addr, VEC[i].data);
      else rcheck(int'(VEC[i].req), VEC[i].addr, VEC[i].data);
    end

    // R2: raw input on source 70 = bank 2, bit 6
    src_i[70] = 1'b1;
    @(negedge clk);
    rcheck(2, 10'h0C0, 32'h40);
    rcheck(5, 10'h0D8, 32'h0);   // R5 still masked
    check(9, {31'd0, irq_o}, 32'd0);  // R9
    bwrite(10'h0C8, 32'h40);
    check(9, {31'd0, irq_o}, 32'd1);  // R9
    check(9, {31'd0, fiq_o}, 32'd0);
    rcheck(2, 10'h0D8, 32'h40);
    rcheck(2, 10'h040, 32'h46);  // winner 70 captured while free
    src_i[70] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(9, {31'd0, irq_o}, 32'd0);

    // R10 soft reset
    bwrite(10'h114, 32'h28);
    bwrite(10'h0C8, 32'h40);
    src_i[70] = 1'b1;
    bwrite(10'h010, 32'h2);
    rcheck(10, 10'h014, 32'h1);
    rcheck(10, 10'h0C4, 32'hFFFFFFFF);
    rcheck(10, 10'h114, 32'h0);
    rcheck(10, 10'h040, 32'h80);
    bwrite(10'h088, 32'h20);
    rcheck(10, 10'h098, 32'h0);  // sw bit of src5 was cleared
    src_i[70] = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule